// File: doc/BRIEF.md
# Storage command sequencer and verifier

This block drives the command side of a storage engine that takes fixed 4-Kbyte transfers. After a start pulse it issues a run of write or read commands. Each command carries a 48-bit block address counted in 512-byte sectors, so consecutive commands step the address by 8. On a write run, 64-bit words come from an external first-word-fall-through pattern FIFO and go straight to the engine. On a read run, each returned word is compared with the FIFO's next expected word.

The engine interface is a stream with back-pressure. `eng_wait` is an inverted ready. A write word or a read command is taken on a clock where the command line is high and `eng_wait` is low. While `eng_wait` is high, the command, address and data hold. Read data comes back in command order as 512 consecutive valid beats per command and cannot be stalled.

The block reports a test-busy flag, a sticky mismatch flag with details of the first mismatch, and a running count of completed bytes. It produces no pattern data and holds no FIFO of its own.

Top module: `stor_cmd_seq`

## Requirements
- R1: A start is taken only while idle and only when `cmd_count` is non-zero. If `start_wr` and `start_rd` are both high, the write run wins. `test_busy` rises on the clock after the start is taken. Start pulses at any other time, or with a zero count, have no effect.
- R2: A command or a write word is accepted on a clock where its command line is high and `eng_wait` is low. While `eng_wait` is high, the command line, `eng_addr` and `eng_wr_data` keep their values into the next cycle. `eng_wr_cmd` and `eng_rd_cmd` are never high together.
- R3: During a write run, `fifo_ack` is high exactly on the cycles that accept a write word, and `eng_wr_data` equals `fifo_data` in the same cycle.
- R4: In a write run, `eng_wr_cmd` rises only after a cycle in which `fifo_count` was at least 512. Write word k of the run carries address `start_addr + 8*floor(k/512)`.
- R5: When the 512th word of a write burst that is not the last is accepted, `eng_wr_cmd` stays high on the next cycle if `fifo_count` was above 544 in the accepting cycle. Otherwise it drops on the next cycle.
- R6: When the final write word of the run is accepted, `eng_wr_cmd` is low on the next cycle.
- R7: In a read run, `eng_rd_cmd` rises after the start. The n-th accepted read command carries `start_addr + 8*n`. The line is low on the cycle after the last command is accepted. Commands do not wait for read data.
- R8: During a read run, each `eng_rd_valid` beat raises `fifo_ack` and is compared with `fifo_data`. The first mismatch sets `test_fail` and captures the expected word, the returned word, and the byte address `start_addr*512 + 8*(beats before it)`. Later mismatches leave the captured values unchanged. The flag and the captured values clear when the next start is taken.
- R9: After the last command, `test_busy` falls two cycles after `eng_busy` goes low, because `eng_busy` is registered first. It falls only if `eng_busy` has been high at least once since the start.
- R10: `byte_count` clears at a start and advances by 8 on every `fifo_ack`. It ends at `cmd_count*4096`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_wr | input | 1 | Start a write run |
| start_rd | input | 1 | Start a read run |
| cmd_count | input | 16 | Number of 4-Kbyte commands in the run |
| start_addr | input | 48 | First block address, in 512-byte sectors |
| fifo_count | input | 13 | Words held in the pattern FIFO |
| fifo_data | input | 64 | Head word of the pattern FIFO |
| fifo_ack | output | 1 | Pops the FIFO head word |
| eng_wait | input | 1 | Engine back-pressure (inverted ready) |
| eng_busy | input | 1 | Engine busy flag |
| eng_rd_valid | input | 1 | Read data beat valid |
| eng_rd_data | input | 64 | Read data beat |
| eng_wr_cmd | output | 1 | Write command, qualifies write data |
| eng_rd_cmd | output | 1 | Read command |
| eng_addr | output | 48 | Command block address |
| eng_wr_data | output | 64 | Write data word |
| test_busy | output | 1 | Run in progress |
| test_fail | output | 1 | Sticky mismatch flag |
| fail_expect | output | 64 | Expected word at first mismatch |
| fail_actual | output | 64 | Returned word at first mismatch |
| fail_addr | output | 57 | Byte address of first mismatch |
| byte_count | output | 57 | Bytes completed in this run |

## Verification
Two functions can fall in the same cycle during a read run: a read command is accepted, and an earlier command's data beat is checked and popped from the FIFO. The bench sets that up by returning data bursts as soon as any command is pending, while random wait-request keeps later commands stalled. It then judges the command addresses, the drop of `eng_rd_cmd` after the last one, the pop count and the mismatch capture independently of each other. On the write side, the burst-boundary decision and the acceptance of the last word of a burst share one cycle. The bench compares the FIFO count it drove in that cycle against 544 to predict whether the command stays high.

// File: rtl/stor_seq_pkg.sv
package stor_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ISSUE,
    ST_WR_WAIT,
    ST_WR_BURST,
    ST_WR_CHECK,
    ST_END_WAIT
  } seq_state_e;
endpackage

// File: rtl/stor_cmd_fsm.sv
module stor_cmd_fsm
  import stor_seq_pkg::*;
#(
  parameter int ADDR_W      = 48,
  parameter int LEN_W       = 16,
  parameter int CNT_W       = 13,
  parameter int BURST_WORDS = 512,
  parameter int PAD_WORDS   = 32,
  parameter int BLK_STEP    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_wr,
  input  logic              start_rd,
  input  logic [LEN_W-1:0]  cmd_count,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  fifo_count,
  input  logic              eng_wait,
  input  logic              eng_busy,
  output logic              wr_cmd,
  output logic              rd_cmd,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              wr_accept,
  output logic              test_busy,
  output logic              load,
  output logic              rd_mode
);
  localparam int WC_W = $clog2(BURST_WORDS);
  localparam logic [CNT_W-1:0]  START_TH = CNT_W'(BURST_WORDS);
  localparam logic [CNT_W-1:0]  CONT_TH  = CNT_W'(BURST_WORDS + PAD_WORDS);
  localparam logic [WC_W-1:0]   PRELAST  = WC_W'(BURST_WORDS - 2);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(BLK_STEP);

  seq_state_e       state;
  logic [WC_W-1:0]  word_idx;
  logic [LEN_W-1:0] cmds_left;
  logic             busy_q, busy_seen;
  logic             rd_accept, last_cmd;

  assign load      = (state == ST_IDLE) && (start_wr || start_rd) && (cmd_count != '0);
  assign wr_accept = wr_cmd && !eng_wait;
  assign rd_accept = rd_cmd && !eng_wait;
  assign last_cmd  = (cmds_left == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wr_cmd    <= 1'b0;
      rd_cmd    <= 1'b0;
      cmd_addr  <= '0;
      word_idx  <= '0;
      cmds_left <= '0;
      test_busy <= 1'b0;
      rd_mode   <= 1'b0;
      busy_q    <= 1'b0;
      busy_seen <= 1'b0;
    end else begin
      busy_q <= eng_busy;
      if (load)        busy_seen <= 1'b0;
      else if (busy_q) busy_seen <= 1'b1;
      case (state)
        ST_IDLE: if (load) begin
          test_busy <= 1'b1;
          cmd_addr  <= start_addr;
          cmds_left <= cmd_count;
          word_idx  <= '0;
          if (start_wr) begin
            rd_mode <= 1'b0;
            state   <= ST_WR_WAIT;
          end else begin
            rd_mode <= 1'b1;
            rd_cmd  <= 1'b1;
            state   <= ST_RD_ISSUE;
          end
        end
        ST_RD_ISSUE: if (rd_accept) begin
          if (last_cmd) begin
            rd_cmd <= 1'b0;
            state  <= ST_END_WAIT;
          end else begin
            cmd_addr  <= cmd_addr + STEP;
            cmds_left <= cmds_left - LEN_W'(1);
          end
        end
        ST_WR_WAIT: if (fifo_count >= START_TH) begin
          wr_cmd   <= 1'b1;
          word_idx <= '0;
          state    <= ST_WR_BURST;
        end
        ST_WR_BURST: if (wr_accept) begin
          word_idx <= word_idx + WC_W'(1);
          if (word_idx == PRELAST) state <= ST_WR_CHECK;
        end
        ST_WR_CHECK: if (wr_accept) begin
          if (last_cmd) begin
            wr_cmd <= 1'b0;
            state  <= ST_END_WAIT;
          end else begin
            cmds_left <= cmds_left - LEN_W'(1);
            cmd_addr  <= cmd_addr + STEP;
            word_idx  <= '0;
            if (fifo_count > CONT_TH) begin
              state <= ST_WR_BURST;
            end else begin
              wr_cmd <= 1'b0;
              state  <= ST_WR_WAIT;
            end
          end
        end
        ST_END_WAIT: if (!busy_q && busy_seen) begin
          test_busy <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_wr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && eng_wait) |=> (wr_cmd && $stable(cmd_addr)));
  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && eng_wait) |=> (rd_cmd && $stable(cmd_addr)));
  assert_one_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_cmd && rd_cmd));
  assert_start_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_busy) |-> $past(state == ST_IDLE));
  assert_end_seen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(test_busy) |-> $past(busy_seen));
endmodule

// File: rtl/stor_rd_check.sv
module stor_rd_check #(
  parameter int DATA_W = 64,
  parameter int BA_W   = 57
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              chk_en,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] exp_data,
  input  logic [BA_W-1:0]   byte_pos,
  output logic              fail,
  output logic [DATA_W-1:0] fail_expect,
  output logic [DATA_W-1:0] fail_actual,
  output logic [BA_W-1:0]   fail_addr
);
  logic mismatch;
  assign mismatch = chk_en && (rd_data != exp_data);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      fail        <= 1'b0;
      fail_expect <= '0;
      fail_actual <= '0;
      fail_addr   <= '0;
    end else if (mismatch && !fail) begin
      fail        <= 1'b1;
      fail_expect <= exp_data;
      fail_actual <= rd_data;
      fail_addr   <= byte_pos;
    end
  end

  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clear) |=> (fail && $stable(fail_actual) && $stable(fail_expect) && $stable(fail_addr)));
  assert_fail_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(chk_en));
endmodule

// File: rtl/stor_cmd_seq.sv
module stor_cmd_seq #(
  parameter int DATA_W       = 64,
  parameter int ADDR_W       = 48,
  parameter int LEN_W        = 16,
  parameter int FIFO_DEPTH   = 4096,
  parameter int BURST_WORDS  = 512,
  parameter int PAD_WORDS    = 32,
  parameter int SECTOR_BYTES = 512
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        start_wr,
  input  logic                                        start_rd,
  input  logic [LEN_W-1:0]                            cmd_count,
  input  logic [ADDR_W-1:0]                           start_addr,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0]             fifo_count,
  input  logic [DATA_W-1:0]                           fifo_data,
  output logic                                        fifo_ack,
  input  logic                                        eng_wait,
  input  logic                                        eng_busy,
  input  logic                                        eng_rd_valid,
  input  logic [DATA_W-1:0]                           eng_rd_data,
  output logic                                        eng_wr_cmd,
  output logic                                        eng_rd_cmd,
  output logic [ADDR_W-1:0]                           eng_addr,
  output logic [DATA_W-1:0]                           eng_wr_data,
  output logic                                        test_busy,
  output logic                                        test_fail,
  output logic [DATA_W-1:0]                           fail_expect,
  output logic [DATA_W-1:0]                           fail_actual,
  output logic [ADDR_W+$clog2(SECTOR_BYTES)-1:0]      fail_addr,
  output logic [ADDR_W+$clog2(SECTOR_BYTES)-1:0]      byte_count
);
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1);
  localparam int SEC_SH    = $clog2(SECTOR_BYTES);
  localparam int BC_W      = ADDR_W + SEC_SH;
  localparam int BYTE_STEP = DATA_W / 8;
  localparam int BLK_STEP  = (BURST_WORDS * BYTE_STEP) / SECTOR_BYTES;

  logic            wr_accept, load, rd_mode;
  logic [BC_W-1:0] base_bytes;

  stor_cmd_fsm #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W),
    .BURST_WORDS(BURST_WORDS), .PAD_WORDS(PAD_WORDS), .BLK_STEP(BLK_STEP)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
    .cmd_count(cmd_count), .start_addr(start_addr), .fifo_count(fifo_count),
    .eng_wait(eng_wait), .eng_busy(eng_busy), .wr_cmd(eng_wr_cmd),
    .rd_cmd(eng_rd_cmd), .cmd_addr(eng_addr), .wr_accept(wr_accept),
    .test_busy(test_busy), .load(load), .rd_mode(rd_mode)
  );

  assign eng_wr_data = fifo_data;
  assign fifo_ack    = wr_accept || (rd_mode && eng_rd_valid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_bytes <= '0;
      byte_count <= '0;
    end else if (load) begin
      base_bytes <= {start_addr, {SEC_SH{1'b0}}};
      byte_count <= '0;
    end else if (fifo_ack) begin
      byte_count <= byte_count + BC_W'(BYTE_STEP);
    end
  end

  stor_rd_check #(.DATA_W(DATA_W), .BA_W(BC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clear(load),
    .chk_en(rd_mode && eng_rd_valid), .rd_data(eng_rd_data),
    .exp_data(fifo_data), .byte_pos(base_bytes + byte_count),
    .fail(test_fail), .fail_expect(fail_expect),
    .fail_actual(fail_actual), .fail_addr(fail_addr)
  );

  assert_wr_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ack && !rd_mode) |-> test_busy);
  assert_count_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (byte_count == '0));
endmodule

// File: tb/stor_cmd_seq_test.sv
module stor_cmd_seq_test;
  localparam int CLK_NS = 10;
  localparam int BW = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic start_wr = 0, start_rd = 0, fifo_ack, eng_wait = 0, eng_busy = 0, eng_rd_valid = 0;
  logic [15:0] cmd_count = '0;
  logic [47:0] start_addr = '0, eng_addr;
  logic [12:0] fifo_count = '0;
  logic [63:0] fifo_data = '0, eng_rd_data = '0, eng_wr_data, fail_expect, fail_actual;
  logic eng_wr_cmd, eng_rd_cmd, test_busy, test_fail;
  logic [56:0] fail_addr, byte_count;

  stor_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
    .cmd_count(cmd_count), .start_addr(start_addr), .fifo_count(fifo_count),
    .fifo_data(fifo_data), .fifo_ack(fifo_ack), .eng_wait(eng_wait),
    .eng_busy(eng_busy), .eng_rd_valid(eng_rd_valid), .eng_rd_data(eng_rd_data),
    .eng_wr_cmd(eng_wr_cmd), .eng_rd_cmd(eng_rd_cmd), .eng_addr(eng_addr),
    .eng_wr_data(eng_wr_data), .test_busy(test_busy), .test_fail(test_fail),
    .fail_expect(fail_expect), .fail_actual(fail_actual),
    .fail_addr(fail_addr), .byte_count(byte_count)
  );

  int n_chk = 0, n_err = 0;

  function automatic logic [63:0] pat(int i);
    return {32'(i * 3) ^ 32'hC3C3_0000, ~32'(i)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // model state
  int rd_ptr, wr_ptr, fill_pct, wait_pct, ncmd, tk, stray_at;
  int wr_words, rd_cmds, pend, burst_left, vidx, corr_a, corr_b;
  int bmode, bcnt, drop_tick, p_cnt, p_accw, p_accr;
  bit ack_q, is_wr, late, st_wr, st_rd, p_wr, p_rd, p_wait;
  logic [15:0] st_cnt;
  logic [47:0] base, p_addr;
  logic [63:0] p_data;
  int e_data, e_addr, e_ack, e_hold, e_thr, e_bnd, e_last, e_rdcmd, e_rdlast, bnd_hi, bnd_lo;

  function automatic bit run_done();
    return is_wr ? (wr_words == ncmd * BW) : (vidx == ncmd * BW && burst_left == 0);
  endfunction

  task automatic tick();
    bit accw, accr;
    @(negedge clk);
    tk++;
    if (ack_q) rd_ptr++;
    if (wr_ptr - rd_ptr < 4096 && $urandom_range(99) < fill_pct) wr_ptr++;
    case (bmode)
      1: begin eng_busy = 1; if (run_done()) begin bmode = 2; bcnt = 4; end end
      2: begin bcnt--; if (bcnt == 0) begin eng_busy = 0; drop_tick = tk; bmode = 6; end end
      3: if (run_done()) begin bmode = 4; bcnt = 20; end
      4: begin
        bcnt--;
        if (bcnt == 0) begin
          chk(test_busy == 1'b1, "R9 no finish before engine busy seen", 64'(test_busy), 64'd1);
          eng_busy = 1; bcnt = 5; bmode = 5;
        end
      end
      5: begin bcnt--; if (bcnt == 0) begin eng_busy = 0; drop_tick = tk; bmode = 6; end end
      default: ;
    endcase
    eng_rd_valid = 0; eng_rd_data = '0;
    if (burst_left == 0 && pend > 0 && $urandom_range(99) < 50) begin burst_left = BW; pend--; end
    if (burst_left > 0) begin
      eng_rd_valid = 1;
      eng_rd_data = pat(vidx) ^ ((vidx == corr_a || vidx == corr_b) ? 64'hFF : 64'h0);
      vidx++; burst_left--;
    end
    fifo_count = 13'(wr_ptr - rd_ptr);
    fifo_data  = pat(rd_ptr);
    eng_wait   = ($urandom_range(99) < wait_pct);
    start_wr = st_wr; start_rd = st_rd || (tk == stray_at); cmd_count = st_cnt; start_addr = base;
    st_wr = 0; st_rd = 0;
    #1;
    accw = eng_wr_cmd && !eng_wait;
    accr = eng_rd_cmd && !eng_wait;
    if (p_wr && p_wait && !(eng_wr_cmd && eng_addr == p_addr && eng_wr_data == p_data)) e_hold++;
    if (p_rd && p_wait && !(eng_rd_cmd && eng_addr == p_addr)) e_hold++;
    if (!p_wr && eng_wr_cmd && p_cnt < BW) e_thr++;
    if (p_accw >= 0 && (p_accw % BW) == BW - 1) begin
      if (p_accw == ncmd * BW - 1) begin
        if (eng_wr_cmd) e_last++;
      end else begin
        if (eng_wr_cmd != (p_cnt > 544)) e_bnd++;
        if (p_cnt > 544) bnd_hi++; else bnd_lo++;
      end
    end
    if (accw) begin
      if (eng_wr_data != pat(wr_words)) e_data++;
      if (eng_addr != base + 48'(8 * (wr_words / BW))) e_addr++;
      if (!fifo_ack) e_ack++;
      p_accw = wr_words; wr_words++;
      if (bmode == 0) bmode = late ? 3 : 1;
    end else p_accw = -1;
    if (is_wr && !accw && fifo_ack) e_ack++;
    if (is_wr && eng_rd_cmd) e_rdcmd++;
    if (p_accr == ncmd - 1 && eng_rd_cmd) e_rdlast++;
    if (accr) begin
      if (eng_addr != base + 48'(8 * rd_cmds)) e_addr++;
      p_accr = rd_cmds; rd_cmds++; pend++;
      if (bmode == 0) bmode = late ? 3 : 1;
    end else p_accr = -1;
    if (!is_wr && fifo_ack != eng_rd_valid) e_ack++;
    ack_q = fifo_ack; p_wr = eng_wr_cmd; p_rd = eng_rd_cmd; p_wait = eng_wait;
    p_addr = eng_addr; p_data = eng_wr_data; p_cnt = int'(fifo_count);
  endtask

  task automatic run(input bit w, input bit r, input int n, input logic [47:0] b,
                     input int wp, input int fp, input int pre, input int ca, input int cb,
                     input bit lt, input int stray_off);
    int guard;
    rd_ptr = 0; wr_ptr = pre; fill_pct = fp; wait_pct = wp; ncmd = n; base = b;
    wr_words = 0; rd_cmds = 0; pend = 0; burst_left = 0; vidx = 0; corr_a = ca; corr_b = cb;
    bmode = 0; late = lt; drop_tick = -100; ack_q = 0; is_wr = w;
    p_wr = 0; p_rd = 0; p_wait = 0; p_accw = -1; p_accr = -1; p_cnt = 0;
    e_data = 0; e_addr = 0; e_ack = 0; e_hold = 0; e_thr = 0; e_bnd = 0; e_last = 0;
    e_rdcmd = 0; e_rdlast = 0; bnd_hi = 0; bnd_lo = 0;
    st_wr = w; st_rd = r; st_cnt = 16'(n); stray_at = -1;
    tick();
    tick();
    chk(test_busy == 1'b1, "R1 test_busy one cycle after start", 64'(test_busy), 64'd1);
    chk(test_fail == 1'b0, "R8 fail cleared by start", 64'(test_fail), 64'd0);
    if (stray_off > 0) stray_at = tk + stray_off;
    guard = 0;
    while (test_busy && guard < 40000) begin tick(); guard++; end
    chk(tk - drop_tick == 2, "R9 test_busy falls two cycles after engine busy", 64'(tk - drop_tick), 64'd2);
    chk(byte_count == 57'(n * 4096), "R10 final byte count", 64'(byte_count), 64'(n * 4096));
    chk(e_hold == 0, "R2 hold under wait-request", 64'(e_hold), 64'd0);
    chk(e_ack == 0, is_wr ? "R3 fifo_ack on accepted words" : "R8 fifo_ack on valid beats", 64'(e_ack), 64'd0);
    if (is_wr) begin
      chk(wr_words == n * BW, "R4 write words accepted", 64'(wr_words), 64'(n * BW));
      chk(e_data == 0, "R3 write data equals FIFO word", 64'(e_data), 64'd0);
      chk(e_addr == 0, "R4 write burst addresses", 64'(e_addr), 64'd0);
      chk(e_thr == 0, "R4 write starts only at 512 words", 64'(e_thr), 64'd0);
      chk(e_bnd == 0, "R5 burst boundary decision", 64'(e_bnd), 64'd0);
      chk(e_last == 0, "R6 write command drops after last word", 64'(e_last), 64'd0);
      chk(e_rdcmd == 0, "R1 no read command during write run", 64'(e_rdcmd), 64'd0);
    end else begin
      chk(rd_cmds == n, "R7 read commands issued", 64'(rd_cmds), 64'(n));
      chk(e_addr == 0, "R7 read command addresses", 64'(e_addr), 64'd0);
      chk(e_rdlast == 0, "R7 read command drops after last", 64'(e_rdlast), 64'd0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    tk = 0; stray_at = -1; st_wr = 0; st_rd = 0; st_cnt = '0; base = '0;
    fill_pct = 0; wait_pct = 0; ncmd = 1; is_wr = 1; bmode = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(test_busy == 0, "R1 reset test_busy", 64'(test_busy), 64'd0);
    chk(eng_wr_cmd == 0 && eng_rd_cmd == 0, "R2 reset commands low", 64'({eng_wr_cmd, eng_rd_cmd}), 64'd0);
    chk(test_fail == 0, "R8 reset fail flag", 64'(test_fail), 64'd0);
    chk(byte_count == 0, "R10 reset byte count", 64'(byte_count), 64'd0);

    // zero-length start is ignored
    st_wr = 1; st_cnt = 16'd0; base = 48'h10;
    tick(); tick(); tick();
    chk(test_busy == 0 && eng_wr_cmd == 0, "R1 zero count ignored", 64'({test_busy, eng_wr_cmd}), 64'd0);

    // write, FIFO kept full: continuous bursts, stray read start mid-run
    run(1, 0, 4, 48'h123, 30, 100, 4096, -1, -1, 0, 40);
    chk(bnd_hi > 0, "R5 continuation case exercised", 64'(bnd_hi), 64'd1);
    // write, FIFO filling slowly: command drops between bursts
    run(1, 0, 3, 48'hFFFF_FFFF_FF00, 20, 60, 600, -1, -1, 0, 0);
    chk(bnd_lo > 0, "R5 pause case exercised", 64'(bnd_lo), 64'd1);
    // clean read
    run(0, 1, 4, 48'h40, 40, 100, 4096, -1, -1, 0, 0);
    chk(test_fail == 0, "R8 no fail on clean read", 64'(test_fail), 64'd0);
    // read with two corrupted beats
    run(0, 1, 3, 48'h2000, 25, 100, 4096, 700, 1500, 0, 0);
    chk(test_fail == 1, "R8 fail set on mismatch", 64'(test_fail), 64'd1);
    chk(fail_expect == pat(700), "R8 captured expected word", fail_expect, pat(700));
    chk(fail_actual == (pat(700) ^ 64'hFF), "R8 captured returned word", fail_actual, pat(700) ^ 64'hFF);
    chk(fail_addr == ({9'd0, 48'h2000} << 9) + 57'(700 * 8), "R8 captured byte address",
        64'(fail_addr), 64'(({9'd0, 48'h2000} << 9) + 57'(700 * 8)));
    // both starts: write wins; engine busy raised late
    run(1, 1, 1, 48'h7, 10, 100, 4096, -1, -1, 1, 0);
    chk(test_fail == 0, "R8 fail stays clear after write run", 64'(test_fail), 64'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule